// File: doc/BRIEF.md
# Floating-Point Issue Hazard Checker

This block sits in the decode stage of an in-order pipeline that feeds four execution units of fixed but unequal latency. The four units are a single-cycle integer unit, a 4-stage pipelined adder, a 7-stage pipelined multiplier and an unpipelined divider that is busy for 24 cycles. Each cycle, decode presents one decoded instruction. It carries the unit select, up to two floating-point source registers and an optional destination register. The block answers with either an issue strobe or a stall. A stalled instruction is held at the inputs until it issues.

Because the units finish at different times, results can return out of order. The block keeps three pieces of state to account for this:
- a countdown, per floating-point register, of the cycles left until that register's pending result lands;
- a shift-register reservation map of the single writeback port;
- a busy counter for the divider.

An instruction issues only when none of the following is present: a read-after-write hazard, a write-after-write hazard that would let a younger result land before an older one, a clash on the writeback port, or a busy divider. No arithmetic is performed here.

Top module: `fp_issue_ctrl`

## Requirements
- R1: After reset, no register has a result pending, no writeback slot is reserved and the divider is idle. The first instruction presented issues in the cycle it is presented.
- R2: `issue_o` is high exactly when `valid_i` is high and `stall_o` is low. `stall_o` is never high while `valid_i` is low.
- R3: The unit select encodes 0 as integer (latency 1), 1 as adder (latency 4), 2 as multiplier (latency 7) and 3 as divider (latency 24). An instruction with latency L that writes register d issues in cycle t. Any later instruction that reads d as a valid source stalls through cycle t+L and may issue from cycle t+L+1.
- R4: Take an older write to register d with k cycles left on its countdown. A younger instruction writing d with latency L stalls while k > L, so the younger result lands strictly after the older one. Equal latencies issued in consecutive cycles do not stall.
- R5: A divide issued in cycle t blocks every other divide until cycle t+25 (divider latency plus one).
- R6: An instruction that writes a register with latency L stalls if an in-flight instruction already holds the writeback port for the cycle L cycles ahead.
- R7: An instruction whose destination-valid flag is low creates no pending entry and reserves no writeback slot. A source whose valid flag is low is ignored when checking for hazards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | A decoded instruction is presented |
| unit_i | input | 2 | Unit select: 0 integer, 1 adder, 2 multiplier, 3 divider |
| dst_i | input | 5 | Destination register index |
| dst_vld_i | input | 1 | Instruction writes `dst_i` |
| src1_i | input | 5 | First source register index |
| src1_vld_i | input | 1 | `src1_i` is read |
| src2_i | input | 5 | Second source register index |
| src2_vld_i | input | 1 | `src2_i` is read |
| stall_o | output | 1 | Presented instruction must wait |
| issue_o | output | 1 | Presented instruction issues this cycle |

## Verification
The assertions assume that decode holds a stalled instruction unchanged until `issue_o` is seen, and that the unit select only takes the four encoded values. The bench's driver keeps to both rules: it applies an instruction just after a rising edge, leaves every field untouched until the issue strobe appears, and only then moves on. The back-to-back properties compare a cycle's issue with the issue of the cycle before. They therefore rely on an instruction being issued at most once, and this holds because the driver lowers or replaces the instruction right after it issues.

// File: rtl/fp_issue_pkg.sv
package fp_issue_pkg;
  typedef enum logic [1:0] {
    UNIT_INT = 2'd0,
    UNIT_ADD = 2'd1,
    UNIT_MUL = 2'd2,
    UNIT_DIV = 2'd3
  } unit_e;
endpackage

// File: rtl/fp_pend_table.sv
module fp_pend_table #(
  parameter int unsigned NUM_REGS = 32,
  parameter int unsigned CW       = 5,
  localparam int unsigned RW      = $clog2(NUM_REGS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          set_i,
  input  logic [RW-1:0] set_idx_i,
  input  logic [CW-1:0] set_val_i,
  input  logic [RW-1:0] rd_a_idx_i,
  input  logic [RW-1:0] rd_b_idx_i,
  input  logic [RW-1:0] rd_d_idx_i,
  output logic [CW-1:0] rd_a_cnt_o,
  output logic [CW-1:0] rd_b_cnt_o,
  output logic [CW-1:0] rd_d_cnt_o
);
  logic [CW-1:0] cnt_q [NUM_REGS];

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cnt_q[r] <= '0;
      end else if (set_i && set_idx_i == RW'(r)) begin
        cnt_q[r] <= set_val_i;
      end else if (cnt_q[r] != '0) begin
        cnt_q[r] <= cnt_q[r] - 1'b1;
      end
    end
  end

  assign rd_a_cnt_o = cnt_q[rd_a_idx_i];
  assign rd_b_cnt_o = cnt_q[rd_b_idx_i];
  assign rd_d_cnt_o = cnt_q[rd_d_idx_i];
endmodule

// File: rtl/fp_wb_reserve.sv
module fp_wb_reserve #(
  parameter int unsigned DEPTH = 24,
  parameter int unsigned CW    = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          claim_i,
  input  logic [CW-1:0] claim_lat_i,
  input  logic [CW-1:0] query_lat_i,
  output logic          conflict_o
);
  // slot_q[k] set: port is taken k cycles from now
  logic [DEPTH:1] slot_q, slot_d;

  for (genvar k = 1; k <= DEPTH; k++) begin : g_slot
    logic shift_in;
    if (k < DEPTH) begin : g_mid
      assign shift_in = slot_q[k+1];
    end else begin : g_top
      assign shift_in = 1'b0;
    end
    assign slot_d[k] = shift_in | (claim_i && (32'(claim_lat_i) == k + 1));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) slot_q <= '0;
    else         slot_q <= slot_d;
  end

  always_comb begin
    conflict_o = 1'b0;
    for (int k = 1; k <= DEPTH; k++) begin
      if (32'(query_lat_i) == k) conflict_o = slot_q[k];
    end
  end
endmodule

// File: rtl/fp_div_track.sv
module fp_div_track #(
  parameter int unsigned LAT = 24,
  parameter int unsigned CW  = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o
);
  logic [CW-1:0] left_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             left_q <= '0;
    else if (start_i)        left_q <= CW'(LAT);
    else if (left_q != '0)   left_q <= left_q - 1'b1;
  end

  assign busy_o = (left_q != '0);
endmodule

// File: rtl/fp_issue_ctrl.sv
module fp_issue_ctrl
  import fp_issue_pkg::*;
#(
  parameter int unsigned NUM_REGS = 32,
  parameter int unsigned INT_LAT  = 1,
  parameter int unsigned ADD_LAT  = 4,
  parameter int unsigned MUL_LAT  = 7,
  parameter int unsigned DIV_LAT  = 24,
  localparam int unsigned RW      = $clog2(NUM_REGS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic [1:0]    unit_i,
  input  logic [RW-1:0] dst_i,
  input  logic          dst_vld_i,
  input  logic [RW-1:0] src1_i,
  input  logic          src1_vld_i,
  input  logic [RW-1:0] src2_i,
  input  logic          src2_vld_i,
  output logic          stall_o,
  output logic          issue_o
);
  localparam int unsigned MAX_AM  = (ADD_LAT > MUL_LAT) ? ADD_LAT : MUL_LAT;
  localparam int unsigned MAX_ID  = (INT_LAT > DIV_LAT) ? INT_LAT : DIV_LAT;
  localparam int unsigned MAX_LAT = (MAX_AM > MAX_ID) ? MAX_AM : MAX_ID;
  localparam int unsigned CW      = $clog2(MAX_LAT + 1);

  unit_e         unit;
  logic [CW-1:0] lat;
  logic [CW-1:0] s1_cnt, s2_cnt, d_cnt;
  logic          wb_clash, div_busy;
  logic          raw_hz, waw_hz, wb_hz, div_hz;

  assign unit = unit_e'(unit_i);

  always_comb begin
    unique case (unit)
      UNIT_INT: lat = CW'(INT_LAT);
      UNIT_ADD: lat = CW'(ADD_LAT);
      UNIT_MUL: lat = CW'(MUL_LAT);
      default:  lat = CW'(DIV_LAT);
    endcase
  end

  fp_pend_table #(.NUM_REGS(NUM_REGS), .CW(CW)) i_pend (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .set_i      (issue_o && dst_vld_i),
    .set_idx_i  (dst_i),
    .set_val_i  (lat),
    .rd_a_idx_i (src1_i),
    .rd_b_idx_i (src2_i),
    .rd_d_idx_i (dst_i),
    .rd_a_cnt_o (s1_cnt),
    .rd_b_cnt_o (s2_cnt),
    .rd_d_cnt_o (d_cnt)
  );

  fp_wb_reserve #(.DEPTH(MAX_LAT), .CW(CW)) i_wb (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .claim_i     (issue_o && dst_vld_i),
    .claim_lat_i (lat),
    .query_lat_i (lat),
    .conflict_o  (wb_clash)
  );

  fp_div_track #(.LAT(DIV_LAT), .CW(CW)) i_div (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (issue_o && unit == UNIT_DIV),
    .busy_o  (div_busy)
  );

  assign raw_hz = (src1_vld_i && s1_cnt != '0) || (src2_vld_i && s2_cnt != '0);
  // younger write must land strictly after the older one
  assign waw_hz = dst_vld_i && (d_cnt > lat);
  assign wb_hz  = dst_vld_i && wb_clash;
  assign div_hz = (unit == UNIT_DIV) && div_busy;

  assign stall_o = valid_i && (raw_hz || waw_hz || wb_hz || div_hz);
  assign issue_o = valid_i && !stall_o;
endmodule

// File: rtl/fp_issue_ctrl_chk.sv
module fp_issue_ctrl_chk #(
  parameter int unsigned INT_LAT = 1,
  parameter int unsigned ADD_LAT = 4,
  parameter int unsigned MUL_LAT = 7,
  parameter int unsigned DIV_LAT = 24,
  parameter int unsigned RW      = 5
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          valid_i,
  input logic [1:0]    unit_i,
  input logic [RW-1:0] dst_i,
  input logic          dst_vld_i,
  input logic [RW-1:0] src1_i,
  input logic          src1_vld_i,
  input logic [RW-1:0] src2_i,
  input logic          src2_vld_i,
  input logic          stall_o,
  input logic          issue_o
);
  int unsigned cur_lat;
  int unsigned since_div;
  logic        div_seen;

  always_comb begin
    case (unit_i)
      2'd0:    cur_lat = INT_LAT;
      2'd1:    cur_lat = ADD_LAT;
      2'd2:    cur_lat = MUL_LAT;
      default: cur_lat = DIV_LAT;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      since_div <= 0;
      div_seen  <= 1'b0;
    end else if (issue_o && unit_i == 2'd3) begin
      since_div <= 1;
      div_seen  <= 1'b1;
    end else if (since_div <= DIV_LAT) begin
      since_div <= since_div + 1;
    end
  end

  assert_issue_gated_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_o |-> (valid_i && !stall_o));

  assert_no_idle_stall_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |-> !stall_o);

  assert_raw_next_src1_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_o && dst_vld_i) |=> !(issue_o && src1_vld_i && src1_i == $past(dst_i)));

  assert_raw_next_src2_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_o && dst_vld_i) |=> !(issue_o && src2_vld_i && src2_i == $past(dst_i)));

  assert_waw_order_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_o && dst_vld_i) |=>
      !(issue_o && dst_vld_i && dst_i == $past(dst_i) && cur_lat < $past(cur_lat)));

  assert_div_spacing_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_o && unit_i == 2'd3 && div_seen) |-> (since_div > DIV_LAT));

  assert_wb_single_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_o && dst_vld_i && cur_lat > 1) |=>
      !(issue_o && dst_vld_i && cur_lat + 1 == $past(cur_lat)));
endmodule

bind fp_issue_ctrl fp_issue_ctrl_chk #(
  .INT_LAT(INT_LAT), .ADD_LAT(ADD_LAT), .MUL_LAT(MUL_LAT), .DIV_LAT(DIV_LAT), .RW(RW)
) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .valid_i    (valid_i),
  .unit_i     (unit_i),
  .dst_i      (dst_i),
  .dst_vld_i  (dst_vld_i),
  .src1_i     (src1_i),
  .src1_vld_i (src1_vld_i),
  .src2_i     (src2_i),
  .src2_vld_i (src2_vld_i),
  .stall_o    (stall_o),
  .issue_o    (issue_o)
);

// File: tb/test_fp_issue_ctrl.sv
`timescale 1ns/1ps
module test_fp_issue_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       valid = 1'b0;
  logic [1:0] unit = '0;
  logic [4:0] dst = '0, src1 = '0, src2 = '0;
  logic       dst_vld = 1'b0, src1_vld = 1'b0, src2_vld = 1'b0;
  logic       stall, issue;

  int    n_chk = 0;
  int    n_fail = 0;
  int    waits = 0;
  bit    done = 1'b0;
  int    exp_q[$];
  string req_q[$];

  always #2 clk = ~clk;

  fp_issue_ctrl i_fp_issue_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .unit_i(unit),
    .dst_i(dst), .dst_vld_i(dst_vld), .src1_i(src1), .src1_vld_i(src1_vld),
    .src2_i(src2), .src2_vld_i(src2_vld), .stall_o(stall), .issue_o(issue)
  );

  // monitor: measure stall cycles per instruction, compare with scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (valid) begin
        n_chk++;
        if (issue == stall) begin
          n_fail++;
          $display("FAIL R2: issue=%0b stall=%0b expected opposite values", issue, stall);
        end
        if (issue) begin
          int    e;
          string r;
          e = exp_q.pop_front();
          r = req_q.pop_front();
          n_chk++;
          if (waits != e) begin
            n_fail++;
            $display("FAIL %s: stall cycles actual %0d expected %0d", r, waits, e);
          end
          waits = 0;
        end else begin
          waits++;
        end
      end else begin
        n_chk++;
        if (stall || issue) begin
          n_fail++;
          $display("FAIL R2: idle cycle stall=%0b issue=%0b expected 0 0", stall, issue);
        end
      end
    end
  end

  task automatic send(input logic [1:0] u, input int d, input bit dv,
                      input int s1, input bit s1v, input int s2, input bit s2v,
                      input int exp_wait, input string req);
    exp_q.push_back(exp_wait);
    req_q.push_back(req);
    unit = u; dst = 5'(d); dst_vld = dv;
    src1 = 5'(s1); src1_vld = s1v; src2 = 5'(s2); src2_vld = s2v;
    valid = 1'b1;
    forever begin
      @(negedge clk);
      if (issue) break;
    end
    @(posedge clk);
    #1 valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    #(4 * 100000);
    n_fail++;
    $display("FAIL watchdog: run did not complete");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    n_chk++;
    if (stall || issue) begin
      n_fail++;
      $display("FAIL R1: after reset stall=%0b issue=%0b expected 0 0", stall, issue);
    end
    @(posedge clk); #1;

    // R1: first instruction issues at once; R3 integer latency 1
    send(2'd0, 12, 1, 0, 0, 0, 0, 0, "R1");
    send(2'd1, 14, 1, 12, 1, 0, 0, 1, "R3 int");
    idle(10);
    // R3 adder on src2, multiplier with partial gap
    send(2'd1, 9, 1, 0, 0, 0, 0, 0, "R3");
    send(2'd2, 15, 1, 0, 0, 9, 1, 4, "R3 add src2");
    idle(20);
    send(2'd2, 10, 1, 0, 0, 0, 0, 0, "R3");
    idle(3);
    send(2'd0, 11, 1, 10, 1, 0, 0, 4, "R3 mul gap");
    idle(20);
    // R3 divider RAW
    send(2'd3, 16, 1, 0, 0, 0, 0, 0, "R3");
    send(2'd0, 17, 1, 16, 1, 0, 0, 24, "R3 div");
    idle(30);
    // R4 WAW: add after div, int after mul, equal latency
    send(2'd3, 5, 1, 0, 0, 0, 0, 0, "R4");
    send(2'd1, 5, 1, 0, 0, 0, 0, 20, "R4 add after div");
    idle(30);
    send(2'd2, 13, 1, 0, 0, 0, 0, 0, "R4");
    send(2'd0, 13, 1, 0, 0, 0, 0, 6, "R4 int after mul");
    idle(20);
    send(2'd2, 13, 1, 0, 0, 0, 0, 0, "R4");
    send(2'd2, 13, 1, 0, 0, 0, 0, 0, "R4 equal latency");
    idle(20);
    // R5 divider structural
    send(2'd3, 3, 1, 0, 0, 0, 0, 0, "R5");
    send(2'd3, 4, 1, 0, 0, 0, 0, 24, "R5 second divide");
    idle(60);
    // R6 writeback port
    send(2'd2, 1, 1, 0, 0, 0, 0, 0, "R6");
    idle(2);
    send(2'd1, 2, 1, 0, 0, 0, 0, 1, "R6 add vs mul");
    idle(20);
    send(2'd1, 1, 1, 0, 0, 0, 0, 0, "R6");
    idle(2);
    send(2'd0, 2, 1, 0, 0, 0, 0, 1, "R6 int vs add");
    idle(20);
    // R7 ignored fields
    send(2'd2, 6, 0, 0, 0, 0, 0, 0, "R7");
    send(2'd1, 8, 1, 6, 1, 0, 0, 0, "R7 no dst no pending");
    idle(20);
    send(2'd2, 7, 1, 0, 0, 0, 0, 0, "R7");
    send(2'd1, 18, 1, 7, 0, 7, 0, 0, "R7 src invalid");
    idle(20);
    send(2'd2, 19, 0, 0, 0, 0, 0, 0, "R7");
    idle(2);
    send(2'd1, 20, 1, 0, 0, 0, 0, 0, "R7 no wb slot");
    idle(20);

    n_chk++;
    if (exp_q.size() != 0) begin
      n_fail++;
      $display("FAIL R2: %0d instructions unissued expected 0", exp_q.size());
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule